// File: doc/BRIEF.md
# Radix-4 Digit-Reversal Reorder Buffer

This block sits behind a radix-4 FFT. The FFT emits each frame with its indices in base-4 digit-reversed order. The block takes those complex samples and puts them back in natural order. It holds the frame in two memory banks that swap roles. While one frame is written into one bank, the frame before it is read out linearly from the other bank.

The write address is the arrival count with its 2-bit base-4 digits in reverse order. The two bits inside each digit keep their positions. The read side walks the other bank from address 0 upward.

A producer pulses the start input for one cycle. It then streams I/Q samples on the following cycles, one per cycle. It may begin a new frame as soon as the busy flag is low again. Output samples are marked by a valid strobe.

Top module: `drev_reorder`

## Requirements
- R1: While reset is asserted, and afterwards until a frame has been accepted, `busy_o` and `out_valid_o` are low.
- R2: A start pulse while `busy_o` is low raises `busy_o` on the next cycle. `busy_o` stays high for exactly 4^DIGITS cycles, one per sample, and falls on the cycle after the last sample.
- R3: The sample that arrives in position k of a frame (k counted from 0) leaves in output position r(k). r(k) is formed by cutting k into 2-bit digits, bits [1:0] being digit 0, and reversing the order of those digits. For example, with three digits, k=6 maps to 36.
- R4: The first output of a frame is valid two cycles after its last input sample. `out_valid_o` then stays high for exactly 4^DIGITS consecutive cycles, and is low otherwise unless a later frame is being read.
- R5: A new frame may start on the first cycle `busy_o` is low, even while the previous frame is still being read. Neither frame corrupts the other.
- R6: A start pulse while `busy_o` is high is ignored. The frame in progress keeps its length and ordering.
- R7: I and Q pass through unaltered as DATA_W-bit two's-complement values, negative values included.
- R8: Asserting reset during a frame clears `busy_o` and `out_valid_o`. The partial frame is dropped. The next frame after reset is reordered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse one clock before the first sample of a frame |
| in_re_i | input | DATA_W | Input sample, real part |
| in_im_i | input | DATA_W | Input sample, imaginary part |
| busy_o | output | 1 | High while a frame is being accepted |
| out_valid_o | output | 1 | High on cycles carrying output data |
| out_re_o | output | DATA_W | Output sample, real part |
| out_im_o | output | DATA_W | Output sample, imaginary part |

## Verification
The bench builds the block with DIGITS=3, giving 64-point frames, and DATA_W=14. Three digits keep frames short enough for many runs. They still exercise a real three-way digit swap, with a middle digit that stays put, which a plain bit reversal would get wrong. Each input sample encodes its frame tag and natural index, with Q as the bitwise complement so that values are negative. Output order, data and first-valid timing can therefore be checked word by word across back-to-back frames, an ignored start, and a reset in mid-frame.

// File: rtl/drev_pkg.sv
package drev_pkg;
  localparam int unsigned MAX_DIGITS = 15;
  localparam int unsigned MAX_AW     = 2 * MAX_DIGITS;

  // reverse the order of 2-bit digits, bits inside a digit unchanged
  function automatic logic [MAX_AW-1:0] digit_rev(input logic [MAX_AW-1:0] idx,
                                                  input int unsigned      digits);
    logic [MAX_AW-1:0] r;
    r = '0;
    for (int unsigned d = 0; d < MAX_DIGITS; d++) begin
      if (d < digits) r[2*(digits-1-d) +: 2] = idx[2*d +: 2];
    end
    return r;
  endfunction
endpackage

// File: rtl/drev_wr_ctrl.sv
module drev_wr_ctrl
  import drev_pkg::*;
#(
  parameter int unsigned DIGITS = 5,
  localparam int unsigned AW    = 2 * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          wr_en_o,
  output logic          wr_bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

  logic          busy_q;
  logic          bank_q;
  logic [AW-1:0] cnt_q;
  logic          last;
  logic [MAX_AW-1:0] rev_full;

  assign last     = (cnt_q == LAST_IDX);
  assign done_o   = busy_q & last;
  assign busy_o   = busy_q;
  assign wr_en_o  = busy_q;
  assign wr_bank_o = bank_q;
  assign rev_full = digit_rev(MAX_AW'(cnt_q), DIGITS);
  assign wr_addr_o = rev_full[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bank_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      cnt_q <= cnt_q + AW'(1);
      if (last) begin
        busy_q <= 1'b0;
        bank_q <= ~bank_q;
      end
    end
  end

  // R2
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) == LAST_IDX));

  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + AW'(1)));
endmodule

// File: rtl/drev_rd_ctrl.sv
module drev_rd_ctrl #(
  parameter int unsigned DIGITS = 5,
  localparam int unsigned AW    = 2 * DIGITS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          bank_i,
  output logic          rd_en_o,
  output logic          rd_bank_o,
  output logic [AW-1:0] rd_addr_o
);
  localparam logic [AW-1:0] LAST_IDX = {AW{1'b1}};

  logic          active_q;
  logic          bank_q;
  logic [AW-1:0] cnt_q;

  assign rd_en_o   = active_q;
  assign rd_bank_o = bank_q;
  assign rd_addr_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      bank_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (done_i) begin
      active_q <= 1'b1;
      bank_q   <= bank_i;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q <= cnt_q + AW'(1);
      if (cnt_q == LAST_IDX) active_q <= 1'b0;
    end
  end

  // R4
  read_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == LAST_IDX && !done_i) |=> !active_q);
endmodule

// File: rtl/drev_pingpong.sv
module drev_pingpong #(
  parameter int unsigned AW     = 10,
  parameter int unsigned DATA_W = 14,
  localparam int unsigned WW    = 2 * DATA_W,
  localparam int unsigned DEPTH = 2 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_bank_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic          rd_bank_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          rd_valid_o,
  output logic [WW-1:0] rd_data_o
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[{wr_bank_i, wr_addr_i}] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= mem[{rd_bank_i, rd_addr_i}];
    end
  end
endmodule

// File: rtl/drev_reorder.sv
module drev_reorder #(
  parameter int unsigned DIGITS = 5,
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] in_re_i,
  input  logic [DATA_W-1:0] in_im_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_re_o,
  output logic [DATA_W-1:0] out_im_o
);
  localparam int unsigned AW = 2 * DIGITS;

  logic          wr_en, wr_bank, done;
  logic [AW-1:0] wr_addr;
  logic          rd_en, rd_bank;
  logic [AW-1:0] rd_addr;
  logic [2*DATA_W-1:0] rd_data;

  drev_wr_ctrl #(.DIGITS(DIGITS)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en),
    .wr_bank_o (wr_bank),
    .wr_addr_o (wr_addr),
    .done_o    (done)
  );

  drev_rd_ctrl #(.DIGITS(DIGITS)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done),
    .bank_i    (wr_bank),
    .rd_en_o   (rd_en),
    .rd_bank_o (rd_bank),
    .rd_addr_o (rd_addr)
  );

  drev_pingpong #(.AW(AW), .DATA_W(DATA_W)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_bank_i  (wr_bank),
    .wr_addr_i  (wr_addr),
    .wr_data_i  ({in_re_i, in_im_i}),
    .rd_en_i    (rd_en),
    .rd_bank_i  (rd_bank),
    .rd_addr_i  (rd_addr),
    .rd_valid_o (out_valid_o),
    .rd_data_o  (rd_data)
  );

  assign out_re_o = rd_data[2*DATA_W-1:DATA_W];
  assign out_im_o = rd_data[DATA_W-1:0];

  // R5
  bank_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rd_en) |-> (wr_bank != rd_bank));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !rd_en) |=> !out_valid_o);
endmodule

// File: tb/tb_drev_reorder.sv
module tb_drev_reorder;
  localparam int DIGITS     = 3;
  localparam int DW         = 14;
  localparam int NPTS       = 1 << (2 * DIGITS);
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [DW-1:0] in_re = '0, in_im = '0;
  logic busy, valid;
  logic [DW-1:0] out_re, out_im;

  drev_reorder #(.DIGITS(DIGITS), .DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .in_re_i(in_re), .in_im_i(in_im),
    .busy_o(busy), .out_valid_o(valid),
    .out_re_o(out_re), .out_im_o(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int tag_q[$];
  int first_q[$];
  int out_idx = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rev(int k);
    int r = 0;
    for (int d = 0; d < DIGITS; d++) r = r * 4 + ((k >> (2 * d)) & 3);
    return r;
  endfunction

  // output monitor: natural order, data, first-valid timing
  always @(negedge clk) begin
    if (rst_ni && valid) begin
      if (tag_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected valid", 1, 0);
      end else begin
        logic [DW-1:0] e;
        e = DW'(tag_q[0] * NPTS + out_idx);
        if (out_idx == 0) chk(cyc == first_q[0], "R4", "first valid cycle", cyc, first_q[0]);
        chk(out_re == e, "R3", "out_re order", int'(out_re), int'(e));
        chk(out_im == ~e, "R7", "out_im value", int'(out_im), int'(~e));
        out_idx++;
        if (out_idx == NPTS) begin
          out_idx = 0;
          void'(tag_q.pop_front());
          void'(first_q.pop_front());
        end
      end
    end
  end

  // caller is #1 after a posedge; returns #1 after the edge following the last sample
  task automatic send_frame(int tag, int inject);
    logic [DW-1:0] v;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    for (int k = 0; k < NPTS; k++) begin
      v = DW'(tag * NPTS + rev(k));
      in_re = v;
      in_im = ~v;
      start = (k == inject);
      if (k < NPTS - 1) begin
        @(posedge clk); #1;
        if (k == inject) chk(busy == 1'b1, "R6", "busy kept after ignored start", int'(busy), 1);
      end
    end
    tag_q.push_back(tag);
    first_q.push_back(cyc + 2);
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b0, "R2", "busy low after last sample", int'(busy), 0);
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 4 * NPTS && tag_q.size() != 0; i++) @(posedge clk);
    chk(tag_q.size() == 0, req, "frames left undrained", tag_q.size(), 0);
    @(negedge clk);
    chk(valid == 1'b0, "R4", "valid low after readout", int'(valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy idle after reset", int'(busy), 0);
    chk(valid == 1'b0, "R1", "valid idle after reset", int'(valid), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_single();
    send_frame(1, -1);
    drain("R3");
  endtask

  task automatic t_back_to_back();
    send_frame(2, -1);
    send_frame(3, -1);
    send_frame(4, -1);
    drain("R5");
  endtask

  task automatic t_ignored_start();
    send_frame(5, 5);
    drain("R6");
  endtask

  task automatic t_reset_mid();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      in_re = DW'(99 * NPTS + k);
      in_im = ~in_re;
      @(posedge clk); #1;
    end
    rst_ni = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R8", "busy cleared by reset", int'(busy), 0);
    chk(valid == 1'b0, "R8", "valid cleared by reset", int'(valid), 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R8", "busy idle after abort", int'(busy), 0);
    send_frame(6, -1);
    drain("R8");
  endtask

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_ignored_start();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule